// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 9-bit words with a write port and a read port, each clocked by its own free-running clock. The two clocks may be unrelated. Write and read pointers cross between the two domains as Gray code through multi-flop synchronisers. The fill level seen by each side is compared against fixed limits, which give the empty and full flags, and against two run-time offsets, which give the near-empty and near-full warnings. All four flags are active low.

The level of a dual-purpose write-side input while reset is held picks the operating mode. When that input is high, it acts as a second, active-high write enable, so several buffers can share a data bus for depth expansion. When it is low, it becomes an active-low load strobe. While the strobe is low, the write port fills the two offset registers a byte at a time in a fixed rotating order. The read side loads its output register only on an accepted read. An output-enable input qualifies the data as valid and blanks it otherwise.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low and after it is released, `empty_n` and `ae_n` are 0, `full_n` and `af_n` are 1, and the output register reads 0.
- R2: The level of `wen2_ld` during reset is held as the mode for as long as reset stays released. 1 selects dual-write-enable mode and 0 selects offset-load mode. In dual-write-enable mode, `wen1_n`=0 with `wen2_ld`=0 loads no offset.
- R3: A word is stored on a rising `wclk` only when `wen1_n`=0 and `wen2_ld`=1. No other combination stores a word.
- R4: The output register takes the oldest stored word on a rising `rclk` only when `ren1_n`=0 and `ren2_n`=0, and holds its value otherwise. Words leave in the order they were written.
- R5: Write requests are ignored while `full_n`=0, and read requests are ignored while `empty_n`=0.
- R6: Once the clocks have settled, `full_n` is 0 exactly when DEPTH words are stored, and `empty_n` is 0 exactly when none are stored. The internal level never exceeds DEPTH.
- R7: Once the clocks have settled, `af_n` is 0 exactly when the level is at least DEPTH minus m, and `ae_n` is 0 exactly when the level is at most n. Here m is the full offset and n is the empty offset, and both are 7 after reset.
- R8: In offset-load mode, a rising `wclk` with `wen1_n`=0 and `wen2_ld`=0 writes `din[7:0]` into the next offset field and stores no word. The fields are filled in the order empty-offset low byte, empty-offset high bits, full-offset low byte, full-offset high bits, and the order then wraps. With `wen2_ld`=1 the port writes words.
- R9: `q_vld` equals the inverse of `oe_n`. `q` carries the output register when `oe_n`=0 and reads 0 when `oe_n`=1.
- R10: Each pointer crosses domains as Gray code, changing at most one bit per source clock. After a write into an empty buffer, `empty_n` rises within 4 `rclk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, common to both sides |
| din | input | DW | Write data; bits 7:0 also feed the offset registers |
| wen1_n | input | 1 | Active-low primary write enable |
| wen2_ld | input | 1 | Mode select during reset; then second write enable (high) or load strobe (low) |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output qualifier |
| q | output | DW | Read data, zero while not qualified |
| q_vld | output | 1 | High while read data is qualified |
| empty_n | output | 1 | Low when empty (read-clock domain) |
| full_n | output | 1 | Low when full (write-clock domain) |
| ae_n | output | 1 | Low when the level is at or below the empty offset |
| af_n | output | 1 | Low when the level is at or above DEPTH minus the full offset |

## Verification
Some properties are checked on every clock edge. These are the one-bit Gray steps of both pointers, the bound on the level seen from each side, and that an empty flag always comes with its near-empty flag and a full flag with its near-full flag. They also include the hold of the output register when a read is not taken, the steadiness of the latched mode, and that an offset load never moves the write pointer. Other behaviour can only be shown by the bench's scenarios. These are the exact flag thresholds for default and loaded offsets, the byte order of the load sequence and its wrap, word order under unrelated clock rates, and the difference between the two modes.

// File: rtl/dcfifo_pflag_pkg.sv
package dcfifo_pflag_pkg;

   // reset value of both level offsets
   localparam int OFS_DEFAULT = 7;

   // meaning of the dual-purpose write input, fixed during reset
   typedef enum logic {
      FM_LOAD   = 1'b0,
      FM_DUALWE = 1'b1
   } fifo_mode_e;

   // rotating target of the offset load strobe
   typedef enum logic [1:0] {
      LS_E_LO = 2'd0,
      LS_E_HI = 2'd1,
      LS_F_LO = 2'd2,
      LS_F_HI = 2'd3
   } ld_step_e;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b = g;
      for (int s = 1; s < 32; s = s * 2) begin
         b = b ^ (b >> s);
      end
      return b;
   endfunction

endpackage

// File: rtl/dcfifo_pflag_sync.sv
module dcfifo_pflag_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dcfifo_pflag_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcfifo_pflag_ofs.sv
module dcfifo_pflag_ofs
   import dcfifo_pflag_pkg::*;
#(
   parameter int OW = 8
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          ld_fire,
   input  logic [7:0]    ld_byte,
   output logic [OW-1:0] e_ofs,
   output logic [OW-1:0] f_ofs
);

   if (OW < 8 || OW > 16) begin : g_bad_ow
      $error("dcfifo_pflag_ofs: OW must lie in 8..16");
   end

   localparam logic [OW-1:0] LO_MASK = OW'(8'hFF);
   localparam logic [OW-1:0] DEF_OFS = OW'(OFS_DEFAULT);

   ld_step_e      step_q;
   logic [OW-1:0] e_q, f_q;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= LS_E_LO;
         e_q    <= DEF_OFS;
         f_q    <= DEF_OFS;
      end else if (ld_fire) begin
         unique case (step_q)
            LS_E_LO: e_q <= (e_q & ~LO_MASK) | OW'(ld_byte);
            LS_E_HI: e_q <= OW'({ld_byte, e_q[7:0]});
            LS_F_LO: f_q <= (f_q & ~LO_MASK) | OW'(ld_byte);
            LS_F_HI: f_q <= OW'({ld_byte, f_q[7:0]});
            default: ;
         endcase
         step_q <= ld_step_e'(step_q + 2'd1);
      end
   end

   assign e_ofs = e_q;
   assign f_ofs = f_q;

   AST_OFS_ONLY_ON_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
      !ld_fire |=> ($stable(e_ofs) && $stable(f_ofs))); // R8

endmodule

// File: rtl/dcfifo_pflag_wctl.sv
module dcfifo_pflag_wctl
   import dcfifo_pflag_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [AW:0]   rgray_s,
   input  logic [AW-1:0] f_ofs,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full_n,
   output logic          af_n
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] wbin_q, wbin_nxt, rbin_s, lvl_nxt, af_lvl;
   logic [PW-1:0] wgray_q;
   logic          full_n_q, af_n_q;

   always_comb begin
      wr_fire  = wr_req && full_n_q;
      wbin_nxt = wbin_q + PW'(wr_fire);
      rbin_s   = PW'(gray2bin(32'(rgray_s)));
      lvl_nxt  = wbin_nxt - rbin_s;
      af_lvl   = PW'(DEPTH) - PW'(f_ofs);
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q   <= '0;
         wgray_q  <= '0;
         full_n_q <= 1'b1;
         af_n_q   <= 1'b1;
      end else begin
         wbin_q   <= wbin_nxt;
         wgray_q  <= PW'(bin2gray(32'(wbin_nxt)));
         full_n_q <= (lvl_nxt != PW'(DEPTH));
         af_n_q   <= (lvl_nxt < af_lvl);
      end
   end

   assign waddr  = wbin_q[AW-1:0];
   assign wgray  = wgray_q;
   assign full_n = full_n_q;
   assign af_n   = af_n_q;

   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
      (PW'(wbin_q - rbin_s) <= PW'(DEPTH))); // R6
   AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n && wr_req) |=> $stable(waddr)); // R5
   AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!rst_n)
      ($countones(wgray ^ $past(wgray)) <= 1)); // R10
   AST_FULL_WITH_AF: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !af_n); // R7

endmodule

// File: rtl/dcfifo_pflag_rctl.sv
module dcfifo_pflag_rctl
   import dcfifo_pflag_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] e_ofs,
   output logic          rd_fire,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          empty_n,
   output logic          ae_n
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] rbin_q, rbin_nxt, wbin_s, lvl_nxt;
   logic [PW-1:0] rgray_q;
   logic          empty_n_q, ae_n_q;

   always_comb begin
      rd_fire  = rd_req && empty_n_q;
      rbin_nxt = rbin_q + PW'(rd_fire);
      wbin_s   = PW'(gray2bin(32'(wgray_s)));
      lvl_nxt  = wbin_s - rbin_nxt;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q    <= '0;
         rgray_q   <= '0;
         empty_n_q <= 1'b0;
         ae_n_q    <= 1'b0;
      end else begin
         rbin_q    <= rbin_nxt;
         rgray_q   <= PW'(bin2gray(32'(rbin_nxt)));
         empty_n_q <= (lvl_nxt != '0);
         ae_n_q    <= (lvl_nxt > PW'(e_ofs));
      end
   end

   assign raddr   = rbin_q[AW-1:0];
   assign rgray   = rgray_q;
   assign empty_n = empty_n_q;
   assign ae_n    = ae_n_q;

   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
      (PW'(wbin_s - rbin_q) <= PW'(DEPTH))); // R6
   AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n && rd_req) |=> $stable(raddr)); // R5
   AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rst_n)
      ($countones(rgray ^ $past(rgray)) <= 1)); // R10
   AST_EMPTY_WITH_AE: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !ae_n); // R7

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
   import dcfifo_pflag_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int DW          = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          wen1_n,
   input  logic          wen2_ld,
   input  logic          ren1_n,
   input  logic          ren2_n,
   input  logic          oe_n,
   output logic [DW-1:0] q,
   output logic          q_vld,
   output logic          empty_n,
   output logic          full_n,
   output logic          ae_n,
   output logic          af_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 256 || DEPTH > 8192 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dcfifo_pflag: DEPTH must be a power of two in 256..8192");
   end
   if (DW < 8) begin : g_bad_dw
      $error("dcfifo_pflag: DW must be at least 8 to carry offset bytes");
   end

   fifo_mode_e    mode_q;
   logic          wr_req, wr_fire, ld_fire, rd_req, rd_fire;
   logic [AW-1:0] waddr, raddr, e_ofs, f_ofs;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] dout_q;

   // mode is captured on every write clock while reset is held
   always_ff @(posedge wclk) begin
      if (!rst_n) mode_q <= fifo_mode_e'(wen2_ld);
   end

   assign wr_req  = !wen1_n && wen2_ld;
   assign ld_fire = (mode_q == FM_LOAD) && !wen1_n && !wen2_ld;
   assign rd_req  = !ren1_n && !ren2_n;

   dcfifo_pflag_ofs #(.OW(AW)) u_ofs (
      .wclk    (wclk),
      .rst_n   (rst_n),
      .ld_fire (ld_fire),
      .ld_byte (din[7:0]),
      .e_ofs   (e_ofs),
      .f_ofs   (f_ofs)
   );

   dcfifo_pflag_wctl #(.AW(AW)) u_wctl (
      .wclk    (wclk),
      .rst_n   (rst_n),
      .wr_req  (wr_req),
      .rgray_s (rgray_s),
      .f_ofs   (f_ofs),
      .wr_fire (wr_fire),
      .waddr   (waddr),
      .wgray   (wgray),
      .full_n  (full_n),
      .af_n    (af_n)
   );

   dcfifo_pflag_rctl #(.AW(AW)) u_rctl (
      .rclk    (rclk),
      .rst_n   (rst_n),
      .rd_req  (rd_req),
      .wgray_s (wgray_s),
      .e_ofs   (e_ofs),
      .rd_fire (rd_fire),
      .raddr   (raddr),
      .rgray   (rgray),
      .empty_n (empty_n),
      .ae_n    (ae_n)
   );

   dcfifo_pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   dcfifo_pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   always_ff @(posedge wclk) begin
      if (wr_fire) mem[waddr] <= din;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (rd_fire) dout_q <= mem[raddr];
   end

   assign q_vld = !oe_n;
   assign q     = oe_n ? '0 : dout_q;

   AST_OUT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
      (ren1_n || ren2_n) |=> $stable(dout_q)); // R4
   AST_EMPTY_OUT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |=> $stable(dout_q)); // R5
   AST_MODE_STEADY: assert property (@(posedge wclk) disable iff (!rst_n)
      $stable(mode_q)); // R2
   AST_LOAD_NO_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
      ld_fire |=> $stable(waddr)); // R8

endmodule

// File: tb/test_dcfifo_pflag.sv
`timescale 1ns/100ps
module test_dcfifo_pflag;

   localparam int DEPTH = 256;
   localparam int DW    = 9;

   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] q;
   logic q_vld, empty_n, full_n, ae_n, af_n;

   int tests = 0, fails = 0;
   int cur_n = 7, cur_m = 7;
   int model[$];
   logic [DW-1:0] last_q = '0;
   bit done = 1'b0;

   always #4 wclk = ~wclk;      // 125 MHz
   always #6.5 rclk = ~rclk;    // unrelated read clock

   dcfifo_pflag #(.DEPTH(DEPTH), .DW(DW)) i_dcfifo_pflag (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din),
      .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
      .oe_n(oe_n), .q(q), .q_vld(q_vld), .empty_n(empty_n), .full_n(full_n),
      .ae_n(ae_n), .af_n(af_n));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_ae_n(input int sz); return sz > cur_n; endfunction
   function automatic bit exp_af_n(input int sz); return sz < DEPTH - cur_m; endfunction

   task automatic settle();
      repeat (12) @(negedge rclk);
      @(negedge wclk);
   endtask

   task automatic chk_flags(input string tag);
      int sz;
      sz = model.size();
      settle();
      check({tag, " empty_n"}, 32'(empty_n), 32'(sz != 0));
      check({tag, " full_n"},  32'(full_n),  32'(sz != DEPTH));
      check({tag, " ae_n"},    32'(ae_n),    32'(exp_ae_n(sz)));
      check({tag, " af_n"},    32'(af_n),    32'(exp_af_n(sz)));
   endtask

   task automatic do_write(input logic [DW-1:0] d, input bit e1, input bit e2);
      @(negedge wclk);
      din = d; wen1_n = e1; wen2_ld = e2;
      if (!e1 && e2 && full_n) model.push_back(int'(d));
      @(posedge wclk); #1;
      wen1_n = 1'b1; wen2_ld = 1'b1;
   endtask

   task automatic do_load(input logic [7:0] b);
      @(negedge wclk);
      din = {1'b0, b}; wen1_n = 1'b0; wen2_ld = 1'b0;
      @(posedge wclk); #1;
      wen1_n = 1'b1; wen2_ld = 1'b1;
   endtask

   task automatic do_read(input bit e1, input bit e2);
      bit acc, emp;
      @(negedge rclk);
      ren1_n = e1; ren2_n = e2;
      emp = !empty_n;
      acc = !e1 && !e2 && empty_n;
      @(posedge rclk); #1;
      ren1_n = 1'b1; ren2_n = 1'b1;
      if (acc) begin
         check("R4 order", 32'(q), 32'(model.pop_front()));
      end else if (emp) begin
         check("R5 read ignored when empty", 32'(q), 32'(last_q));
      end else begin
         check("R4 hold", 32'(q), 32'(last_q));
      end
      last_q = q;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge wclk);
      rst_n = 1'b0; wen2_ld = mode; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
      repeat (4) @(negedge wclk);
      #1;
      check("R1 empty_n in reset", 32'(empty_n), 32'd0);
      check("R1 full_n in reset",  32'(full_n),  32'd1);
      @(negedge wclk);
      rst_n = 1'b1;
      @(negedge wclk);
      wen2_ld = 1'b1;
      model.delete();
      last_q = '0;
      cur_n = 7; cur_m = 7;
   endtask

   task automatic fill_to(input int lvl, input int base);
      while (model.size() < lvl) do_write(DW'(base + model.size()), 1'b0, 1'b1);
   endtask

   task automatic drain();
      while (model.size() > 0) do_read(1'b0, 1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int lat;
      void'($urandom(32'd20240611));

      // dual write enable mode, reset state
      do_reset(1'b1);
      settle();
      check("R1 empty_n", 32'(empty_n), 32'd0);
      check("R1 ae_n",    32'(ae_n),    32'd0);
      check("R1 full_n",  32'(full_n),  32'd1);
      check("R1 af_n",    32'(af_n),    32'd1);
      check("R1 q zero",  32'(q),       32'd0);

      // R3: only wen1_n=0 with wen2_ld=1 stores
      do_write(9'h055, 1'b0, 1'b0);
      do_write(9'h066, 1'b1, 1'b1);
      do_write(9'h077, 1'b1, 1'b0);
      chk_flags("R3 no store");

      // R10: empty flag latency
      do_write(9'h101, 1'b0, 1'b1);
      lat = 0;
      while (!empty_n && lat < 10) begin
         @(posedge rclk); #1; lat++;
      end
      check("R10 empty_n latency<=4", 32'(lat <= 4), 32'd1);

      // R4: one enable alone does not read
      do_read(1'b0, 1'b1);
      do_read(1'b1, 1'b0);
      chk_flags("R4 partial enable");
      do_read(1'b0, 1'b0);
      do_read(1'b0, 1'b0);   // R5 on empty

      // R2/R7 default thresholds (wen2 low writes above loaded nothing)
      fill_to(7, 16);          chk_flags("R2 R7 level 7");
      fill_to(8, 16);          chk_flags("R7 level 8");
      fill_to(DEPTH - 8, 16);  chk_flags("R7 level D-8");
      fill_to(DEPTH - 7, 16);  chk_flags("R7 level D-7");
      fill_to(DEPTH, 16);      chk_flags("R6 full");
      repeat (3) do_write(9'h1EE, 1'b0, 1'b1);   // R5 ignored while full
      chk_flags("R5 writes ignored when full");
      drain();
      chk_flags("R6 empty after drain");

      // random traffic with unrelated clocks
      fork
         begin
            for (int i = 0; i < 1500; i++)
               do_write(DW'($urandom), ($urandom % 10) < 3, ($urandom % 8) != 0);
         end
         begin
            for (int i = 0; i < 1500; i++)
               do_read(($urandom % 5) == 0, ($urandom % 5) == 0);
         end
      join
      drain();
      chk_flags("R6 random end");

      // R9 output qualifier
      @(negedge rclk); oe_n = 1'b1; #1;
      check("R9 q blank", 32'(q), 32'd0);
      check("R9 q_vld low", 32'(q_vld), 32'd0);
      oe_n = 1'b0; #1;
      check("R9 q_vld high", 32'(q_vld), 32'd1);
      check("R9 q restored", 32'(q), 32'(last_q));

      // offset load mode
      do_reset(1'b0);
      do_load(8'd20); do_load(8'd0); do_load(8'd30); do_load(8'd0);
      cur_n = 20; cur_m = 30;
      chk_flags("R8 load stores no word");
      fill_to(20, 64);         chk_flags("R8 level n");
      fill_to(21, 64);         chk_flags("R8 level n+1");
      fill_to(DEPTH - 31, 64); chk_flags("R8 level D-m-1");
      fill_to(DEPTH - 30, 64); chk_flags("R8 level D-m");
      drain();
      do_load(8'd5);           // wraps to empty offset low byte
      cur_n = 5;
      fill_to(5, 3);           chk_flags("R8 wrap level 5");
      fill_to(6, 3);           chk_flags("R8 wrap level 6");
      drain();
      chk_flags("R2 load mode empty");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule